// File: doc/BRIEF.md
# Reset Sequencing Controller

This block owns the single internal reset of a small 8-bit processor core. It merges three sources: an active-low reset pin that must stay low long enough to count, a software watchdog that firmware restarts by a memory-mapped write, and a trap that fires when the core fetches an opcode from an address that holds neither RAM nor program ROM. The core reset stays asserted for as long as any source requires. The block then runs a fixed two-cycle vector fetch that builds the new program counter and hands it to the core.

The pin passes through a two-flop synchronizer and a low-width filter. A source inside the chip holds the reset for a fixed number of cycles before the vector fetch. During the fetch the block drives the vector address and captures the returned byte in the same cycle. The high byte comes from the vector address and the low byte from the next address. A one-cycle load strobe then presents the assembled counter, and the core reset falls on that same edge. A two-bit cause field records which source produced the latest reset and keeps that value until the next reset begins.

Top module: `rst_seq_ctrl`

## Requirements
- R1: A pin held low across at least PIN_MIN (default 2) consecutive clock edges, as seen at the synchronizer output, asserts core_rst and sets rst_cause to 2'b01. A pin low for one clock cycle is ignored: core_rst stays 0 and rst_cause keeps its value.
- R2: After an accepted pin reset, core_rst stays high until pc_load appears. pc_load is observed in the cycle that follows the fifth rising edge after the pin returns high. The first of those edges starts the sequence.
- R3: The vector fetch has two cycles with vec_rd high. The first drives vec_addr = VEC_ADDR (0x7FE) and the second drives VEC_ADDR+1 (0x7FF). pc_new is {byte read at 0x7FE, byte read at 0x7FF}. pc_load is a single-cycle pulse, and core_rst falls on the edge that raises it.
- R4: A write with wr_data[0] = 0 to WDOG_ADDR (0x7F0) restarts the watchdog count. A write with wr_data[0] = 1, or a write to any other address, leaves the count unchanged.
- R5: If the watchdog is not restarted, the reset fires WDOG_LIMIT edges after the edge that ended the previous reset, and rst_cause becomes 2'b10.
- R6: An opcode fetch (fetch_op high) outside [RAM_LO, RAM_HI] and outside [ROM_LO, ROM_HI] asserts core_rst on the next edge with rst_cause = 2'b11. Writes to such addresses, and fetches inside either range, cause no reset.
- R7: rst_cause changes only when a new reset starts and holds its value while the core runs.
- R8: Every reset, from any source, restarts the watchdog, so the next timeout is a full WDOG_LIMIT edges after pc_load.
- R9: A watchdog or illegal-fetch reset keeps core_rst high for HOLD_CYC cycles before the vector fetch. pc_load is therefore observed HOLD_CYC+2 cycles after core_rst is first seen high.
- R10: An illegal fetch on the same edge as a watchdog expiry is recorded as 2'b11. A pin reset accepted during an internal reset takes over the sequence and records 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| cpu_addr | input | ADDR_W | Core address bus |
| fetch_op | input | 1 | High when the current access is an opcode fetch |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | input | 8 | Memory read data during the vector fetch |
| core_rst | output | 1 | Active-high reset to the core |
| vec_rd | output | 1 | Vector read in progress |
| vec_addr | output | ADDR_W | Vector byte address |
| pc_load | output | 1 | One-cycle strobe: pc_new is valid |
| pc_new | output | 16 | Assembled program counter |
| rst_cause | output | 2 | Cause of the latest reset: 01 pin, 10 watchdog, 11 illegal fetch |

## Verification
The bench walks every address of the 12-bit space through an opcode fetch, preceded by a data write to each illegal address. A range compare that is off by one at any bound therefore produces a spurious reset or a missed one at that single address. It places a restart write at every offset of the watchdog window, including the expiry edge itself. A counter that tests the wrong count, or that lets expiry override a restart on the same edge, shifts the measured timeout. It sweeps pin pulse widths from one to five cycles, so a filter that passes single-cycle glitches, or that swallows two-cycle pulses, is exposed. It also forces an illegal fetch onto the expiry edge and a pin reset into an internal hold, so a wrong priority shows up as a wrong cause code.

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned RAM_LO     = 'h0C0,
  parameter int unsigned RAM_HI     = 'h0FF,
  parameter int unsigned ROM_LO     = 'h300,
  parameter int unsigned ROM_HI     = 'h7FF,
  parameter int unsigned WDOG_ADDR  = 'h7F0,
  parameter int unsigned VEC_ADDR   = 'h7FE,
  parameter int unsigned WDOG_LIMIT = 8192,
  parameter int unsigned HOLD_CYC   = 4,
  parameter int unsigned PIN_MIN    = 2
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              fetch_op,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_data,
  output logic              core_rst,
  output logic              vec_rd,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              pc_load,
  output logic [15:0]       pc_new,
  output logic [1:0]        rst_cause
);

  localparam int WD_W   = $clog2(WDOG_LIMIT);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam int PIN_W  = $clog2(PIN_MIN + 1);
  localparam logic [ADDR_W-1:0] RAM_L = ADDR_W'(RAM_LO);
  localparam logic [ADDR_W-1:0] RAM_H = ADDR_W'(RAM_HI);
  localparam logic [ADDR_W-1:0] ROM_L = ADDR_W'(ROM_LO);
  localparam logic [ADDR_W-1:0] ROM_H = ADDR_W'(ROM_HI);
  localparam logic [ADDR_W-1:0] WD_A  = ADDR_W'(WDOG_ADDR);
  localparam logic [ADDR_W-1:0] VEC_A = ADDR_W'(VEC_ADDR);
  localparam logic [1:0] C_PIN = 2'b01, C_WDG = 2'b10, C_ILL = 2'b11;

  typedef enum logic [2:0] {ST_PIN, ST_HOLD, ST_VHI, ST_VLO, ST_RUN} st_t;

  st_t              state;
  logic             s1, s2;
  logic [PIN_W-1:0] low_cnt;
  logic [WD_W-1:0]  wd_cnt;
  logic [HOLD_W-1:0] hold_cnt;
  logic [7:0]       pc_hi, pc_lo;

  always_ff @(posedge clk) begin
    s1 <= rst_pin_n;
    s2 <= s1;
  end

  wire pin_hit = !s2 && (low_cnt == PIN_W'(PIN_MIN - 1));

  always_ff @(posedge clk)
    if (s2)                              low_cnt <= '0;
    else if (low_cnt != PIN_W'(PIN_MIN)) low_cnt <= low_cnt + 1'b1;

  wire in_ram    = (cpu_addr >= RAM_L) && (cpu_addr <= RAM_H);
  wire in_rom    = (cpu_addr >= ROM_L) && (cpu_addr <= ROM_H);
  wire illegal   = fetch_op && !in_ram && !in_rom;
  wire wd_clear  = wr_en && (cpu_addr == WD_A) && !wr_data[0];
  wire wd_expire = (wd_cnt == WD_W'(WDOG_LIMIT - 1)) && !wd_clear;
  wire running   = (state == ST_RUN);

  always_ff @(posedge clk)
    if (!running || wd_clear || wd_expire) wd_cnt <= '0;
    else                                   wd_cnt <= wd_cnt + 1'b1;

  always_ff @(posedge clk) begin
    pc_load <= 1'b0;
    if (pin_hit) begin
      state     <= ST_PIN;
      rst_cause <= C_PIN;
    end else begin
      case (state)
        ST_PIN:  if (s2) state <= ST_VHI;
        ST_HOLD: begin
          hold_cnt <= hold_cnt + 1'b1;
          if (hold_cnt == HOLD_W'(HOLD_CYC - 1)) state <= ST_VHI;
        end
        ST_VHI: begin
          pc_hi <= rd_data;
          state <= ST_VLO;
        end
        ST_VLO: begin
          pc_lo   <= rd_data;
          pc_load <= 1'b1;
          state   <= ST_RUN;
        end
        default: begin
          if (illegal) begin
            state     <= ST_HOLD;
            rst_cause <= C_ILL;
            hold_cnt  <= '0;
          end else if (wd_expire) begin
            state     <= ST_HOLD;
            rst_cause <= C_WDG;
            hold_cnt  <= '0;
          end
        end
      endcase
    end
  end

  assign core_rst = !running;
  assign vec_rd   = (state == ST_VHI) || (state == ST_VLO);
  assign vec_addr = (state == ST_VLO) ? VEC_A + 1'b1 : VEC_A;
  assign pc_new   = {pc_hi, pc_lo};

  AST_VEC_PAIR: assert property (@(posedge clk) disable iff (!s2)
    (vec_rd && vec_addr == VEC_A) |=> (vec_rd && vec_addr == VEC_A + 1'b1)); // R3
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!s2)
    pc_load |=> !pc_load); // R3
  AST_LOAD_ENDS_RST: assert property (@(posedge clk) disable iff (!s2)
    $fell(core_rst) |-> pc_load); // R3
  AST_ILLEGAL_TRAP: assert property (@(posedge clk) disable iff (!s2)
    (!core_rst && illegal && !pin_hit) |=> (core_rst && rst_cause == C_ILL)); // R6
  AST_WDOG_TRIP: assert property (@(posedge clk) disable iff (!s2)
    (!core_rst && wd_expire && !illegal && !pin_hit) |=> (core_rst && rst_cause == C_WDG)); // R5
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!s2)
    !core_rst |=> (core_rst || $stable(rst_cause))); // R7
  AST_WDOG_FRESH: assert property (@(posedge clk) disable iff (!s2)
    pc_load |-> (wd_cnt == '0)); // R8

endmodule

// File: tb/rst_seq_ctrl_test.sv
module rst_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int L = 40;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst_pin_n;
  logic [11:0] cpu_addr;
  logic        fetch_op, wr_en;
  logic [7:0]  wr_data, rd_data;
  logic        core_rst, vec_rd, pc_load;
  logic [11:0] vec_addr;
  logic [15:0] pc_new;
  logic [1:0]  rst_cause;
  logic [7:0]  seed_hi, seed_lo;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_data = (vec_addr == 12'h7FF) ? seed_lo : seed_hi;

  rst_seq_ctrl #(.WDOG_LIMIT(L), .HOLD_CYC(H)) uut (
    .clk(clk), .rst_pin_n(rst_pin_n), .cpu_addr(cpu_addr), .fetch_op(fetch_op),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .core_rst(core_rst),
    .vec_rd(vec_rd), .vec_addr(vec_addr), .pc_load(pc_load), .pc_new(pc_new),
    .rst_cause(rst_cause));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pick_seed(input int i);
    seed_hi = 8'(i * 37 + 5);
    seed_lo = 8'(i * 91 + 3);
  endtask

  task automatic finish_load(input string tag, input int exp_lat);
    int k;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!pc_load && k < 60);
    chk({tag, " latency"}, k, exp_lat);
    chk("R3 pc_new", pc_new, {seed_hi, seed_lo});
    chk("R3 core_rst low at load", core_rst, 0);
  endtask

  task automatic run_wd(input int d, input int kind, output int k);
    k = 0;
    forever begin
      if (k == d) begin
        wr_en    = 1'b1;
        cpu_addr = (kind == 2) ? 12'h7F1 : 12'h7F0;
        wr_data  = (kind == 1) ? 8'h01 : 8'hFE;
      end
      @(negedge clk);
      k++;
      wr_en = 1'b0;
      if (core_rst || k > 300) break;
    end
  endtask

  task automatic illegal_fetch(input logic [11:0] a);
    cpu_addr = a;
    fetch_op = 1'b1;
    @(negedge clk);
    fetch_op = 1'b0;
  endtask

  task automatic pin_pulse(input int w);
    rst_pin_n = 1'b0;
    repeat (w) @(negedge clk);
    rst_pin_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL timeout: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    int sd;
    sd = 1;
    rst_pin_n = 1'b0; cpu_addr = '0; fetch_op = 0; wr_en = 0; wr_data = '0;
    pick_seed(sd);
    repeat (6) @(negedge clk);
    chk("R1 reset state core_rst", core_rst, 1);

    rst_pin_n = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (i <= 2) chk("R3 no vec before start", vec_rd, 0);
      if (i == 3) chk("R3 first vec addr", {vec_rd, vec_addr}, {1'b1, 12'h7FE});
      if (i == 4) chk("R3 second vec addr", {vec_rd, vec_addr}, {1'b1, 12'h7FF});
      if (i <= 4) chk("R2 held in reset", core_rst, 1);
      if (i == 5) begin
        chk("R2 load after release", pc_load, 1);
        chk("R3 pc_new", pc_new, {seed_hi, seed_lo});
        chk("R1 cause pin", rst_cause, 2'b01);
      end
    end
    @(negedge clk);
    chk("R3 load single cycle", pc_load, 0);

    for (int w = 1; w <= 5; w++) begin
      sd++; pick_seed(sd);
      pin_pulse(w);
      if (w == 1) begin
        repeat (8) @(negedge clk);
        chk("R1 glitch ignored core_rst", core_rst, 0);
        chk("R1 glitch ignored cause", rst_cause, 2'b01);
      end else begin
        finish_load("R2 pin width", 5);
        chk("R1 cause pin", rst_cause, 2'b01);
      end
    end

    sd++; pick_seed(sd);
    run_wd(-1, 0, k);
    chk("R5 timeout length", k, L);
    chk("R5 cause watchdog", rst_cause, 2'b10);
    finish_load("R9 hold length", H + 2);

    for (int d = 0; d < L; d++) begin
      sd++; pick_seed(sd);
      run_wd(d, 0, k);
      chk("R4 restart shifts timeout", k, d + 1 + L);
      chk("R5 cause watchdog", rst_cause, 2'b10);
      finish_load("R9 hold length", H + 2);
    end

    for (int kind = 1; kind <= 2; kind++)
      for (int j = 0; j < 4; j++) begin
        int d;
        d = (j == 0) ? 0 : (j == 1) ? 5 : (j == 2) ? L - 2 : L - 1;
        run_wd(d, kind, k);
        chk("R4 non-restart write ignored", k, L);
        finish_load("R9 hold length", H + 2);
      end

    repeat (25) @(negedge clk);
    sd++; pick_seed(sd);
    illegal_fetch(12'hF00);
    chk("R6 illegal fetch resets", core_rst, 1);
    finish_load("R9 hold length", H + 2);
    run_wd(-1, 0, k);
    chk("R8 full timeout after any reset", k, L);
    finish_load("R9 hold length", H + 2);

    repeat (L - 1) @(negedge clk);
    chk("R10 still running before expiry", core_rst, 0);
    illegal_fetch(12'h900);
    chk("R10 collision resets", core_rst, 1);
    chk("R10 illegal beats watchdog", rst_cause, 2'b11);
    finish_load("R9 hold length", H + 2);

    pin_pulse(1);
    repeat (6) @(negedge clk);
    chk("R7 cause held across glitch", rst_cause, 2'b11);
    chk("R1 glitch ignored core_rst", core_rst, 0);

    sd++; pick_seed(sd);
    illegal_fetch(12'h020);
    pin_pulse(4);
    finish_load("R10 pin takeover latency", 5);
    chk("R10 pin takes over cause", rst_cause, 2'b01);

    for (int a = 0; a < 4096; a++) begin
      logic ill;
      ill = !((a >= 'h0C0 && a <= 'h0FF) || (a >= 'h300 && a <= 'h7FF));
      cpu_addr = 12'h7F0; wr_en = 1'b1; wr_data = 8'h00;
      @(negedge clk);
      wr_en = 1'b0;
      if (ill) begin
        cpu_addr = 12'(a); wr_en = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6 data write ignored", core_rst, 0);
        sd++; pick_seed(sd);
      end
      illegal_fetch(12'(a));
      chk("R6 fetch decode", core_rst, ill);
      if (ill) begin
        chk("R6 cause illegal", rst_cause, 2'b11);
        finish_load("R9 hold length", H + 2);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule